// File: doc/BRIEF.md
# Duplicating Data Register with Select Gating and Parity Check

This block is a word-wide register placed between a memory controller and a heavily loaded bus. On each rising clock edge it captures a data word and drives that word onto two identical output buses, so that each half of the load gets its own driver. Two active-low chip-select inputs can freeze the register. When a strap input enables this gating and both selects are inactive (high), the register keeps its contents and the outputs do not move. When the strap is low, the selects have no effect on the data. They are only captured and passed through, like any other input.

The controller sends an even-parity bit for each word one advancing cycle after the word itself. The block combines that bit with the XOR of the registered word, and one advancing cycle later it reports a mismatch on an active-low error output. The data path and the parity path stall together under select gating. An asynchronous active-low reset clears everything at once, forces the data outputs low and the error flag high, and overrides the gating.

A three-state control machine sequences the pipeline:

- **ST_EMPTY**: reset has been applied and no word has entered the register yet.
- **ST_ACTIVE**: the last edge advanced the pipeline.
- **ST_STALL**: the last edge was held by gating.

The transitions are:

- T_FIRST_WORD: ST_EMPTY to ST_ACTIVE on an advancing edge.
- T_WAIT_EMPTY: ST_EMPTY to ST_EMPTY on a held edge.
- T_FREEZE: ST_ACTIVE to ST_STALL on a held edge.
- T_KEEP: ST_ACTIVE to ST_ACTIVE on an advancing edge.
- T_STAY: ST_STALL to ST_STALL on a held edge.
- T_RESUME: ST_STALL to ST_ACTIVE on an advancing edge.
- Reset returns the machine to ST_EMPTY from any state.

While the machine is in ST_EMPTY, no word is in the register yet. A parity bit offered on that first advancing edge belongs to no word, so the block ignores it.

Top module: `regbuf_par`

## Requirements
- R1: On a rising clock edge that is not held, both output buses take the value on `d_in`, and `q_a` always equals `q_b`.
- R2: Driving `rst_n` low clears both output buses and `sel_q_n` to 0 and sets `perr_n` to 1 at once, without waiting for a clock edge.
- R3: When `gate_en` is 1 and both `sel_a_n` and `sel_b_n` are 1 at an edge, that edge is held: `q_a`, `q_b` and `perr_n` keep their values, and `par_in` and `d_in` at that edge have no effect.
- R4: When `gate_en` is 0, the select inputs have no effect on the data: every edge captures `d_in`.
- R5: `sel_q_n` captures {`sel_b_n`, `sel_a_n`} (bit 0 is `sel_a_n`) on every rising edge, whether the edge is held or not and in either gating mode.
- R6: Parity is even. The parity bit for a word is sampled at the next advancing edge after that word is captured. At the advancing edge after that, `perr_n` becomes 0 if the XOR of the word's bits and its parity bit is 1, and becomes 1 otherwise.
- R7: A `par_in` value present at the first advancing edge after reset is ignored: it cannot drive `perr_n` low.
- R8: After reset is released, if `d_in` and `par_in` stay 0, both output buses stay 0 and `perr_n` stays 1.
- R9: Reset takes priority over gating: asserting `rst_n` low during held cycles still clears the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_in | input | DATA_W (28) | Data word from the controller |
| par_in | input | 1 | Even-parity bit for the previous advancing word |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b_n | input | 1 | Chip select B, active low |
| gate_en | input | 1 | Strap: 1 enables select gating, 0 disables it |
| q_a | output | DATA_W (28) | Registered data, copy A |
| q_b | output | DATA_W (28) | Registered data, copy B |
| sel_q_n | output | 2 | Registered selects, bit 0 is A |
| perr_n | output | 1 | Parity error flag, active low |

## Verification
The bench builds the block with the default 28-bit word and two output copies. With the full width, an all-ones word (even bit count) and alternating patterns exercise the complete XOR tree. Single-bit words give odd-parity cases with one bit flipped. A stimulus table mixes held and advancing edges in both strap settings, so the stall of the data and parity pipeline is checked against an independent model of the pipeline. Directed tests cover reset asserted in mid-run during a held cycle, quiet release from reset, and a stray parity bit on the first word.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_STALL  = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/regbuf_ctl.sv
module regbuf_ctl
    import regbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic sel_a_n,
    input  logic sel_b_n,
    output logic adv,
    output logic hold,
    output logic par_arm
);

    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       hold_w;

    assign hold_w = gate_en & sel_a_n & sel_b_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        adv     = ~hold_w;
        hold    = hold_w;
        par_arm = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                par_arm = 1'b0;
                if (!hold_w) state_d = ST_ACTIVE;
                else         state_d = ST_EMPTY;
            end
            ST_ACTIVE: begin
                par_arm = 1'b1;
                if (hold_w) state_d = ST_STALL;
                else        state_d = ST_ACTIVE;
            end
            ST_STALL: begin
                par_arm = 1'b1;
                if (hold_w) state_d = ST_STALL;
                else        state_d = ST_ACTIVE;
            end
            default: begin
                par_arm = 1'b0;
                state_d = ST_EMPTY;
            end
        endcase
    end

    AST_ARM_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> par_arm); // R7

    AST_EMPTY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_arm && hold) |=> !par_arm); // R7

endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout #(
    parameter int DATA_W = 28,
    parameter int COPIES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           adv,
    input  logic                           hold,
    input  logic [DATA_W-1:0]              d_in,
    output logic [COPIES-1:0][DATA_W-1:0]  q_bank
);

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        logic [DATA_W-1:0] bank_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= '0;
            end else if (adv) begin
                bank_q <= d_in;
            end
        end

        assign q_bank[c] = bank_q;

        AST_HOLD_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            hold |=> $stable(bank_q)); // R3
    end

endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity #(
    parameter int DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              hold,
    input  logic              par_arm,
    input  logic              par_in,
    input  logic [DATA_W-1:0] word,
    output logic              perr_n
);

    logic par_q;
    logic wx_q;
    logic err_n_q;
    logic word_x;

    assign word_x = ^word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q   <= 1'b0;
            wx_q    <= 1'b0;
            err_n_q <= 1'b1;
        end else if (adv) begin
            par_q   <= par_arm ? par_in : 1'b0;
            wx_q    <= word_x;
            err_n_q <= ~(par_q ^ wx_q);
        end
    end

    assign perr_n = err_n_q;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(perr_n)); // R3

    AST_FIRST_PAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !par_arm) |=> !par_q); // R7

endmodule

// File: rtl/regbuf_par.sv
module regbuf_par #(
    parameter int DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              par_in,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              gate_en,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic [1:0]        sel_q_n,
    output logic              perr_n
);

    localparam int COPIES = 2;

    logic                          adv;
    logic                          hold;
    logic                          par_arm;
    logic [COPIES-1:0][DATA_W-1:0] q_bank;
    logic [1:0]                    sel_q;

    regbuf_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (gate_en),
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .adv     (adv),
        .hold    (hold),
        .par_arm (par_arm)
    );

    regbuf_fanout #(
        .DATA_W (DATA_W),
        .COPIES (COPIES)
    ) u_fanout (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .hold   (hold),
        .d_in   (d_in),
        .q_bank (q_bank)
    );

    regbuf_parity #(
        .DATA_W (DATA_W)
    ) u_parity (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .hold    (hold),
        .par_arm (par_arm),
        .par_in  (par_in),
        .word    (q_bank[0]),
        .perr_n  (perr_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 2'b00;
        end else begin
            sel_q <= {sel_b_n, sel_a_n};
        end
    end

    assign q_a     = q_bank[0];
    assign q_b     = q_bank[1];
    assign sel_q_n = sel_q;

    AST_ADV_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (q_a == $past(d_in))); // R1

    AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_a == q_b)); // R1

    AST_NOGATE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (q_b == $past(d_in))); // R4

    AST_SEL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel_q_n == $past({sel_b_n, sel_a_n}))); // R5

endmodule

// File: tb/regbuf_par_bench.sv
module regbuf_par_bench;

    localparam int DW = 28;
    localparam int NV = 12;

    // stimulus: {d_in, par_in, sel_a_n, sel_b_n, gate_en}
    localparam logic [31:0] VEC [0:NV-1] = '{
        {28'h0000000, 1'b1, 1'b0, 1'b0, 1'b1},
        {28'h0000001, 1'b0, 1'b0, 1'b0, 1'b1},
        {28'h0000003, 1'b1, 1'b0, 1'b0, 1'b1},
        {28'hFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b1},
        {28'h5555555, 1'b1, 1'b0, 1'b0, 1'b1},
        {28'h5555555, 1'b0, 1'b1, 1'b1, 1'b1},
        {28'h0ABCDEF, 1'b1, 1'b1, 1'b1, 1'b1},
        {28'h1234567, 1'b0, 1'b1, 1'b0, 1'b1},
        {28'h7654321, 1'b0, 1'b0, 1'b1, 1'b1},
        {28'h0F0F0F0, 1'b1, 1'b1, 1'b1, 1'b0},
        {28'h0000000, 1'b0, 1'b1, 1'b1, 1'b0},
        {28'h8000000, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic [DW-1:0] d_in = '0;
    logic          par_in = 1'b0;
    logic          sel_a_n = 1'b0;
    logic          sel_b_n = 1'b0;
    logic          gate_en = 1'b1;
    logic [DW-1:0] q_a;
    logic [DW-1:0] q_b;
    logic [1:0]    sel_q_n;
    logic          perr_n;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] m_q;
    logic          m_s2par;
    logic          m_s2x;
    logic          m_perr;
    logic          m_armed;
    logic [1:0]    m_sel;

    always #10 clk = ~clk;

    regbuf_par #(.DATA_W(DW)) u_regbuf_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_in    (d_in),
        .par_in  (par_in),
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .gate_en (gate_en),
        .q_a     (q_a),
        .q_b     (q_b),
        .sel_q_n (sel_q_n),
        .perr_n  (perr_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_q = '0; m_s2par = 1'b0; m_s2x = 1'b0; m_perr = 1'b1;
        m_armed = 1'b0; m_sel = 2'b00;
    endtask

    task automatic step(input logic [31:0] v);
        logic hold;
        {d_in, par_in, sel_a_n, sel_b_n, gate_en} = v;
        @(posedge clk);
        hold  = v[0] & v[2] & v[1];
        m_sel = {v[1], v[2]};
        if (!hold) begin
            m_perr  = ~(m_s2par ^ m_s2x);
            m_s2par = m_armed ? v[3] : 1'b0;
            m_s2x   = ^m_q;
            m_q     = v[31:4];
            m_armed = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic compare_all(input string tag);
        check({"R1 q_a ", tag}, 32'(q_a), 32'(m_q));
        check({"R1 q_b ", tag}, 32'(q_b), 32'(q_a));
        check({"R6 perr_n ", tag}, 32'(perr_n), 32'(m_perr));
        check({"R5 sel_q_n ", tag}, 32'(sel_q_n), 32'(m_sel));
    endtask

    initial begin
        #(20 * 5000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        model_reset();
        #2;
        check("R2 reset q_a", 32'(q_a), 32'h0);
        check("R2 reset perr_n", 32'(perr_n), 32'h1);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 first par ignored plus main table walk (R1 R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i]);
            compare_all($sformatf("vec%0d", i));
        end

        // R6 single-bit error: odd word, parity bit wrong then right
        step({28'h0000100, 1'b0, 1'b0, 1'b0, 1'b1});
        step({28'h0000000, 1'b0, 1'b0, 1'b0, 1'b1});
        step({28'h0000000, 1'b0, 1'b0, 1'b0, 1'b1});
        check("R6 single-bit error flagged", 32'(perr_n), 32'h0);
        step({28'h0000100, 1'b0, 1'b0, 1'b0, 1'b1});
        step({28'h0000000, 1'b1, 1'b0, 1'b0, 1'b1});
        step({28'h0000000, 1'b0, 1'b0, 1'b0, 1'b1});
        check("R6 correct parity clears flag", 32'(perr_n), 32'h1);

        // R3 held edges with changing data and parity
        step({28'h00000F0, 1'b1, 1'b0, 1'b0, 1'b1});
        step({28'h0000AAA, 1'b1, 1'b1, 1'b1, 1'b1});
        step({28'h0000BBB, 1'b0, 1'b1, 1'b1, 1'b1});
        check("R3 hold keeps q_a", 32'(q_a), 32'h00000F0);
        compare_all("hold");

        // R9 + R2 reset while held, asynchronous
        #3 rst_n = 1'b0;
        #1;
        model_reset();
        check("R9 reset during hold q_a", 32'(q_a), 32'h0);
        check("R9 reset during hold q_b", 32'(q_b), 32'h0);
        check("R2 async sel_q_n", 32'(sel_q_n), 32'h0);
        check("R2 async perr_n", 32'(perr_n), 32'h1);
        @(negedge clk);
        {d_in, par_in, sel_a_n, sel_b_n, gate_en} = {28'h0, 1'b0, 1'b0, 1'b0, 1'b1};
        rst_n = 1'b1;

        // R8 quiet release
        for (int k = 0; k < 3; k++) begin
            step({28'h0000000, 1'b0, 1'b0, 1'b0, 1'b1});
            check("R8 q stays low", 32'(q_a | q_b), 32'h0);
            check("R8 perr_n stays high", 32'(perr_n), 32'h1);
        end

        // R7 stray parity bit on first word after reset
        rst_n = 1'b0;
        #1 model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step({28'h0000000, 1'b1, 1'b0, 1'b0, 1'b1});
        step({28'h0000000, 1'b0, 1'b0, 1'b0, 1'b1});
        step({28'h0000000, 1'b0, 1'b0, 1'b0, 1'b1});
        check("R7 first par ignored", 32'(perr_n), 32'h1);

        // R4 gating off: selects high still capture
        step({28'h0C0FFEE, 1'b0, 1'b1, 1'b1, 1'b0});
        check("R4 gate off captures", 32'(q_b), 32'h0C0FFEE);
        compare_all("gateoff");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule